// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This unit holds the 32-bit control and status word that governs SIMD floating-point execution. The low six bits are sticky exception flags. Bits 12 down to 7 hold one mask per exception, in the same order as the flags. Bit 6 and bits 15:13 are control fields that the unit stores but does not interpret. The upper half is reserved and always reads as zero.

Software writes the word with a load and reads it back through a store port that is always visible. An execution unit reports exceptions each cycle through a plain strobe and a six-bit vector. Reported exceptions OR into the flags. When a report names any exception whose mask bit is clear, a one-cycle trap pulse is raised, together with the set of unmasked causes. A load that clears a mask while the matching flag is already set does not trap by itself. The trap waits for a later report of that same exception. A load with any reserved bit set is refused with a fault pulse, and the register keeps its value.

All pins are plain control and status signals. A load is taken in the cycle `ld_en` is high, with no back-pressure. Rounding and arithmetic are not part of this unit.

Top module: `simd_csr_unit`

## Requirements
- R1: After reset the register reads 0x0000_1F80, and `trap`, `trap_cause` and `ld_fault` are low.
- R2: A load whose bits [31:16] are all zero writes bits [15:0] into the register. The new value is visible on `csr_rd` one cycle later.
- R3: A load with any bit in [31:16] set leaves the register unchanged and pulses `ld_fault` high for exactly one cycle, one cycle after the load.
- R4: A load that clears mask bits whose flags are already set raises no trap.
- R5: Flags are sticky. A report ORs `op_exc` into bits [5:0], and no flag bit goes from 1 to 0 except through an accepted load.
- R6: One cycle after an `op_valid` report, `trap` is high for one cycle if `op_exc[i]` is 1 while mask bit 7+i is 0, for any i. `trap_cause` equals exactly those bits.
- R7: A report in which every set exception is masked raises no trap, but still sets the matching flags.
- R8: When a load and a report fall in the same cycle, the trap decision uses the masks held before the load. The resulting flags are the loaded flags ORed with `op_exc`.
- R9: `csr_rd` always shows zero in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe |
| ld_data | input | 32 | Value to load |
| ld_fault | output | 1 | Refused-load pulse (reserved bit set) |
| op_valid | input | 1 | Execution-unit report strobe |
| op_exc | input | 6 | Exceptions reported by the operation |
| trap | output | 1 | Unmasked-exception pulse |
| trap_cause | output | 6 | Unmasked exceptions behind the pulse |
| csr_rd | output | 32 | Current register value for store |

## Verification
The hardest state to reach is a register that holds a set flag under a cleared mask without having trapped. From the ports, this needs a masked report first, then a load that drops the mask while keeping the flag. A directed sequence builds exactly that state, checks that no pulse appears, and then issues a report of the same exception to show the deferred trap. A same-cycle load and report are also driven directly, because random stimulus rarely lines up a mask change with a report. Random traffic with a fixed seed, including occasional reserved-bit loads, covers the remaining mixes.

// File: rtl/simd_csr_pkg.sv
package simd_csr_pkg;
  localparam int CSR_W     = 32;
  localparam int NUM_EXC   = 6;
  localparam int MASK_LSB  = 7;
  localparam int RSV_LSB   = 16;
  localparam logic [CSR_W-1:0] CSR_RESET = 32'h0000_1F80;
endpackage

// File: rtl/csr_load_check.sv
module csr_load_check #(
  parameter int CSR_W   = 32,
  parameter int RSV_LSB = 16
) (
  input  logic [CSR_W-1:0] ld_data,
  output logic             ld_ok
);
  always_comb ld_ok = ~|ld_data[CSR_W-1:RSV_LSB];
endmodule

// File: rtl/csr_trap_eval.sv
module csr_trap_eval #(
  parameter int NUM_EXC  = 6,
  parameter int STORE_W  = 16,
  parameter int MASK_LSB = 7
) (
  input  logic [STORE_W-1:0] csr_q,
  input  logic               op_valid,
  input  logic [NUM_EXC-1:0] op_exc,
  output logic [NUM_EXC-1:0] unmasked
);
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_exc
    assign unmasked[i] = op_valid & op_exc[i] & ~csr_q[MASK_LSB+i];
  end
endmodule

// File: rtl/simd_csr_unit.sv
module simd_csr_unit
  import simd_csr_pkg::*;
#(
  parameter int NUM_EXC_P  = NUM_EXC,
  parameter int MASK_LSB_P = MASK_LSB,
  parameter int RSV_LSB_P  = RSV_LSB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic [CSR_W-1:0]     ld_data,
  output logic                 ld_fault,
  input  logic                 op_valid,
  input  logic [NUM_EXC_P-1:0] op_exc,
  output logic                 trap,
  output logic [NUM_EXC_P-1:0] trap_cause,
  output logic [CSR_W-1:0]     csr_rd
);
  localparam int STORE_W = RSV_LSB_P;
  localparam int ZERO_W  = CSR_W - RSV_LSB_P;

  logic [STORE_W-1:0]   csr_q, csr_d;
  logic                 ld_ok;
  logic [NUM_EXC_P-1:0] unm;

  csr_load_check #(.CSR_W(CSR_W), .RSV_LSB(RSV_LSB_P)) u_chk (
    .ld_data(ld_data), .ld_ok(ld_ok));

  csr_trap_eval #(.NUM_EXC(NUM_EXC_P), .STORE_W(STORE_W), .MASK_LSB(MASK_LSB_P)) u_trap (
    .csr_q(csr_q), .op_valid(op_valid), .op_exc(op_exc), .unmasked(unm));

  // An accepted load replaces the word; a report in the same cycle then ORs in.
  always_comb begin
    csr_d = (ld_en && ld_ok) ? ld_data[STORE_W-1:0] : csr_q;
    if (op_valid) csr_d[NUM_EXC_P-1:0] = csr_d[NUM_EXC_P-1:0] | op_exc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q      <= CSR_RESET[STORE_W-1:0];
      ld_fault   <= 1'b0;
      trap       <= 1'b0;
      trap_cause <= '0;
    end else begin
      csr_q      <= csr_d;
      ld_fault   <= ld_en && !ld_ok;
      trap       <= |unm;
      trap_cause <= unm;
    end
  end

  assign csr_rd = {{ZERO_W{1'b0}}, csr_q};
endmodule

// File: rtl/simd_csr_checker.sv
module simd_csr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_en,
  input logic [31:0] ld_data,
  input logic        ld_fault,
  input logic        op_valid,
  input logic [5:0]  op_exc,
  input logic        trap,
  input logic [5:0]  trap_cause,
  input logic [31:0] csr_rd
);
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd[31:16] == 16'h0);
  // R3
  fault_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_data[31:16] != 16'h0 && !op_valid) |=> (ld_fault && $stable(csr_rd)));
  // R5
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ((($past(csr_rd[5:0])) & ~csr_rd[5:0]) == 6'h0));
  // R6
  trap_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!trap && trap_cause == 6'h0));
  // R4
  load_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !op_valid) |=> !trap);
  // R6
  cause_matches_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap == (trap_cause != 6'h0));
endmodule

bind simd_csr_unit simd_csr_checker u_chk_bind (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data), .ld_fault(ld_fault),
  .op_valid(op_valid), .op_exc(op_exc), .trap(trap), .trap_cause(trap_cause),
  .csr_rd(csr_rd));

// File: tb/sim_simd_csr_unit.sv
module sim_simd_csr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        op_valid = 1'b0;
  logic [5:0]  op_exc = '0;
  logic        ld_fault, trap;
  logic [5:0]  trap_cause;
  logic [31:0] csr_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] m_csr;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_csr_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_unmasked(input logic [31:0] m, input logic ov, input logic [5:0] oe);
    return ov ? (oe & ~m[12:7]) : 6'h0;
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] m, input logic le, input logic [31:0] ld,
                                           input logic ov, input logic [5:0] oe);
    logic [31:0] n;
    n = (le && ld[31:16] == 16'h0) ? {16'h0, ld[15:0]} : m;
    if (ov) n[5:0] = n[5:0] | oe;
    return n;
  endfunction

  // Called at a negedge: drive, then check at the following negedge.
  task automatic step(input logic le, input logic [31:0] ld, input logic ov, input logic [5:0] oe,
                      input string tag);
    logic [5:0]  e_cause;
    logic        e_fault;
    logic [31:0] e_csr;
    e_cause = exp_unmasked(m_csr, ov, oe);
    e_fault = le && ld[31:16] != 16'h0;
    e_csr   = exp_next(m_csr, le, ld, ov, oe);
    ld_en = le; ld_data = ld; op_valid = ov; op_exc = oe;
    @(negedge clk);
    ld_en = 1'b0; op_valid = 1'b0;
    m_csr = e_csr;
    chk(csr_rd == e_csr, {tag, " csr"}, csr_rd, e_csr);
    chk(trap == (e_cause != 6'h0) && trap_cause == e_cause, {tag, " trap"},
        {25'h0, trap, trap_cause}, {25'h0, e_cause != 6'h0, e_cause});
    chk(ld_fault == e_fault, {tag, " fault"}, {31'h0, ld_fault}, {31'h0, e_fault});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_csr = 32'h0000_1F80;
    // R1 reset state
    chk(csr_rd == 32'h1F80, "R1 csr", csr_rd, 32'h1F80);
    chk(!trap && !ld_fault && trap_cause == 6'h0, "R1 pulses",
        {24'h0, trap, ld_fault, trap_cause}, 32'h0);
    // R7 masked report sets flag only
    step(1'b0, 32'h0, 1'b1, 6'h21, "R7");
    // R2 plain load clears everything
    step(1'b1, 32'h0000_0000, 1'b0, 6'h0, "R2");
    // R6 unmasked report traps
    step(1'b0, 32'h0, 1'b1, 6'h01, "R6");
    step(1'b0, 32'h0, 1'b0, 6'h0, "R6 single pulse");
    // Build flags under masks, then unmask: no trap (R4)
    step(1'b1, 32'h0000_1F80, 1'b0, 6'h0, "R2 remask");
    step(1'b0, 32'h0, 1'b1, 6'h3F, "R7 all masked");
    step(1'b1, 32'h0000_003F, 1'b0, 6'h0, "R4 unmask set flags");
    step(1'b0, 32'h0, 1'b0, 6'h0, "R4 quiet");
    // Deferred trap on later report of that exception (R6)
    step(1'b0, 32'h0, 1'b1, 6'h04, "R6 deferred");
    // R3 reserved-bit load refused
    step(1'b1, 32'h0001_0000, 1'b0, 6'h0, "R3 bit16");
    step(1'b1, 32'h8000_1F80, 1'b0, 6'h0, "R3 bit31");
    // R5 flags sticky across reports
    step(1'b0, 32'h0, 1'b1, 6'h00, "R5");
    // R8 same-cycle load and report: pre-load masks decide
    step(1'b1, 32'h0000_1F80, 1'b1, 6'h02, "R8");
    step(1'b1, 32'h0000_0000, 1'b1, 6'h10, "R8 masked before");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic        le, ov;
      logic [31:0] ld;
      le = ($urandom % 4) == 0;
      ov = ($urandom % 2) == 0;
      ld = {($urandom % 6 == 0) ? 16'($urandom) : 16'h0, 16'($urandom)};
      step(le, ld, ov, 6'($urandom), "R6 random");
      chk(csr_rd[31:16] == 16'h0, "R9 reserved", csr_rd, {16'h0, csr_rd[15:0]});
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule